// File: doc/BRIEF.md
# I2C Byte FIFO Threshold and Drain Notifier

This block sits between the software-facing side of an I2C master and its bit shifter. It holds one byte queue for data leaving the controller and one for data arriving, and it tells the host when it is worth moving data. The host sets a threshold for each direction. A "ready" request rises when a whole threshold's worth of bytes can be moved in one burst. A "drain" request rises when the remaining message is shorter than that threshold, so the host can finish the tail of the message.

A 16-bit configuration word carries the two thresholds, each stored as the value minus one. It also carries a self-clearing flush bit per direction and a per-direction DMA enable that only gates a DMA request line. A byte counter holds how many bytes of the current message the shifter still has to move. It counts down as the shifter takes or delivers bytes. The queue depth is fixed at build time as 8 shifted left by a 2-bit size code, and that code is reported read-only in bits [15:14] of a buffer status word. The shifter and the SCL/SDA pins are outside this block. Overrun and underflow events are reported as one-cycle pulses.

Top module: `i2c_fifo_notify`

## Requirements
- R1: The configuration word keeps the transmit threshold field in bits [5:0], the transmit DMA enable in bit 7, the receive threshold field in bits [13:8] and the receive DMA enable in bit 15. An effective threshold is the field plus one (1 to 64). On readback, bits 6 and 14 and all other unused bits are 0.
- R2: Writing the configuration word with bit 6 set empties the transmit queue at that same clock edge. Bit 14 does the same for the receive queue. The thresholds written alongside are kept.
- R3: The buffer status word has the size code in bits [15:14] and zeros elsewhere. The queue depth is 8 << code, which is 16 for the default code 1.
- R4: tx_ready is 1 exactly when the count is nonzero, the count is at least the transmit threshold, and the transmit queue has at least that many free entries.
- R5: rx_ready is 1 exactly when the count is nonzero, the count is at least the receive threshold, and the receive queue holds at least that many bytes.
- R6: tx_drain (rx_drain) is 1 exactly when the count is nonzero and below the transmit (receive) threshold. In that case the matching ready request stays 0.
- R7: While the count is zero, all four ready and drain requests are 0.
- R8: A count write loads the count. Otherwise the count drops by one for each byte the shifter takes from the transmit queue and for each byte it puts into the receive queue, and it stops at zero.
- R9: When the shifter delivers a byte while the receive queue is full, rx_ovr pulses for one cycle and the byte is discarded.
- R10: When the shifter asks for a byte while the transmit queue is empty, tx_udf pulses for one cycle and the count does not change.
- R11: Both queues hand bytes out in the order they went in. sh_tx_data and host_rx_data show the head byte.
- R12: tx_dma_req is transmit DMA enable AND (tx_ready OR tx_drain). rx_dma_req is formed the same way from the receive side.
- R13: A host push into a full transmit queue is ignored. A host pop from an empty receive queue is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word to write |
| cfg_rdata | output | 16 | Configuration word readback |
| buf_status | output | 16 | Buffer status word (size code in [15:14]) |
| cnt_wr | input | 1 | Load strobe for the byte count |
| cnt_wdata | input | CNT_W | Byte count to load |
| cnt_rdata | output | CNT_W | Bytes still to be moved by the shifter |
| host_tx_push | input | 1 | Host writes one byte into the transmit queue |
| host_tx_data | input | 8 | Byte written by the host |
| host_rx_pop | input | 1 | Host removes the head byte of the receive queue |
| host_rx_data | output | 8 | Head byte of the receive queue |
| sh_tx_req | input | 1 | Shifter takes the head byte of the transmit queue |
| sh_tx_data | output | 8 | Head byte of the transmit queue |
| sh_rx_valid | input | 1 | Shifter delivers one received byte |
| sh_rx_data | input | 8 | Byte delivered by the shifter |
| tx_ready | output | 1 | A full transmit threshold can be written |
| tx_drain | output | 1 | Transmit tail shorter than the threshold |
| rx_ready | output | 1 | A full receive threshold can be read |
| rx_drain | output | 1 | Receive tail shorter than the threshold |
| tx_dma_req | output | 1 | Gated transmit DMA request |
| rx_dma_req | output | 1 | Gated receive DMA request |
| tx_udf | output | 1 | One-cycle transmit underflow pulse |
| rx_ovr | output | 1 | One-cycle receive overrun pulse |

## Verification
The ready, drain and DMA requests are combinational decodes of registered queue levels, the count and the configuration. They are therefore valid just after the rising edge that captured the push, pop, flush or count write, with no further cycle of latency. The head bytes and the count follow the same rule. The overrun and underflow pulses are registered: each is high only during the cycle after the edge that saw the offending request, and is gone one edge later. The bench drives every input 1 ns after a rising edge and reads every output 1 ns after the next one, so each check lands in exactly the cycle these rules name. The pulses are read both in their cycle and in the cycle after.

// File: rtl/fifonote_pkg.sv
package fifonote_pkg;

    localparam int BYTE_W    = 8;
    localparam int THR_FLD_W = 6;
    localparam int THR_W     = THR_FLD_W + 1;
    localparam int WORD_W    = 16;

    // Bit positions inside the configuration word
    localparam int TX_THR_LSB   = 0;
    localparam int TX_FLUSH_BIT = 6;
    localparam int TX_DMA_BIT   = 7;
    localparam int RX_THR_LSB   = 8;
    localparam int RX_FLUSH_BIT = 14;
    localparam int RX_DMA_BIT   = 15;
    localparam int SIZE_LSB     = 14;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } dir_e;

    typedef struct packed {
        logic [THR_FLD_W-1:0] thr_m1;
        logic                 dma_en;
    } dir_cfg_t;

    typedef struct packed {
        logic ready;
        logic drain;
        logic dma;
    } dir_req_t;

    function automatic int depth_of(input int code);
        return 8 << code;
    endfunction

    function automatic logic [THR_W-1:0] thr_decode(input logic [THR_FLD_W-1:0] fld);
        return {1'b0, fld} + THR_W'(1);
    endfunction

    function automatic dir_cfg_t cfg_field(input logic [WORD_W-1:0] w, input dir_e d);
        dir_cfg_t c;
        if (d == DIR_TX) begin
            c.thr_m1 = w[TX_THR_LSB +: THR_FLD_W];
            c.dma_en = w[TX_DMA_BIT];
        end else begin
            c.thr_m1 = w[RX_THR_LSB +: THR_FLD_W];
            c.dma_en = w[RX_DMA_BIT];
        end
        return c;
    endfunction

    function automatic logic [WORD_W-1:0] cfg_pack(input dir_cfg_t tx, input dir_cfg_t rx);
        logic [WORD_W-1:0] w;
        w = '0;
        w[TX_THR_LSB +: THR_FLD_W] = tx.thr_m1;
        w[TX_DMA_BIT]              = tx.dma_en;
        w[RX_THR_LSB +: THR_FLD_W] = rx.thr_m1;
        w[RX_DMA_BIT]              = rx.dma_en;
        return w;
    endfunction

endpackage

// File: rtl/fifonote_fifo.sv
module fifonote_fifo
    import fifonote_pkg::*;
#(
    parameter int   DEPTH = 16,
    parameter dir_e SIDE  = DIR_TX,
    localparam int  AW    = $clog2(DEPTH),
    localparam int  LW    = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  byte_t         push_data,
    input  logic          pop,
    output byte_t         head,
    output logic [LW-1:0] level,
    output logic          sh_moved
);

    byte_t          mem [DEPTH];
    logic [AW-1:0]  wp_q;
    logic [AW-1:0]  rp_q;
    logic [LW-1:0]  lvl_q;
    logic           push_ok;
    logic           pop_ok;

    assign push_ok = push && !flush && (lvl_q != LW'(DEPTH));
    assign pop_ok  = pop  && !flush && (lvl_q != '0);

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wp_q  <= '0;
            rp_q  <= '0;
            lvl_q <= '0;
        end else begin
            if (push_ok) wp_q <= wp_q + AW'(1);
            if (pop_ok)  rp_q <= rp_q + AW'(1);
            case ({push_ok, pop_ok})
                2'b10:   lvl_q <= lvl_q + LW'(1);
                2'b01:   lvl_q <= lvl_q - LW'(1);
                default: lvl_q <= lvl_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push_ok) mem[wp_q] <= push_data;
    end

    assign head  = mem[rp_q];
    assign level = lvl_q;

    // The shifter pops the transmit queue and pushes the receive queue
    generate
        if (SIDE == DIR_TX) begin : g_tx_side
            assign sh_moved = pop_ok;
        end else begin : g_rx_side
            assign sh_moved = push_ok;
        end
    endgenerate

endmodule

// File: rtl/fifonote_regs.sv
module fifonote_regs
    import fifonote_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_wr,
    input  logic [WORD_W-1:0] cfg_wdata,
    input  logic              cnt_wr,
    input  logic [CNT_W-1:0]  cnt_wdata,
    input  logic [1:0]        dec_amt,
    output dir_cfg_t          tx_cfg,
    output dir_cfg_t          rx_cfg,
    output logic              tx_flush,
    output logic              rx_flush,
    output logic [CNT_W-1:0]  cnt
);

    dir_cfg_t         tx_q;
    dir_cfg_t         rx_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] dec_w;

    assign dec_w = CNT_W'(dec_amt);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
            rx_q <= '0;
        end else if (cfg_wr) begin
            tx_q <= cfg_field(cfg_wdata, DIR_TX);
            rx_q <= cfg_field(cfg_wdata, DIR_RX);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (cnt_wr) begin
            cnt_q <= cnt_wdata;
        end else if (dec_amt != 2'd0) begin
            cnt_q <= (cnt_q > dec_w) ? (cnt_q - dec_w) : '0;
        end
    end

    // Flush bits are strobes: acted on at the write edge, never stored
    assign tx_flush = cfg_wr && cfg_wdata[TX_FLUSH_BIT];
    assign rx_flush = cfg_wr && cfg_wdata[RX_FLUSH_BIT];
    assign tx_cfg   = tx_q;
    assign rx_cfg   = rx_q;
    assign cnt      = cnt_q;

endmodule

// File: rtl/fifonote_notify.sv
module fifonote_notify
    import fifonote_pkg::*;
#(
    parameter dir_e DIR   = DIR_TX,
    parameter int   DEPTH = 16,
    parameter int   CNT_W = 16,
    localparam int  LW    = $clog2(DEPTH) + 1
) (
    input  dir_cfg_t         cfg,
    input  logic [LW-1:0]    level,
    input  logic [CNT_W-1:0] cnt,
    output dir_req_t         req
);

    logic [31:0] thr32;
    logic [31:0] cnt32;
    logic [31:0] avail32;
    logic        cnt_live;
    logic        cnt_short;

    assign thr32 = 32'(thr_decode(cfg.thr_m1));
    assign cnt32 = 32'(cnt);

    // Transmit side counts free slots, receive side counts stored bytes
    generate
        if (DIR == DIR_TX) begin : g_free
            assign avail32 = 32'(DEPTH) - 32'(level);
        end else begin : g_fill
            assign avail32 = 32'(level);
        end
    endgenerate

    assign cnt_live  = (cnt32 != 32'd0);
    assign cnt_short = (cnt32 < thr32);

    assign req.ready = cnt_live && !cnt_short && (avail32 >= thr32);
    assign req.drain = cnt_live && cnt_short;
    assign req.dma   = cfg.dma_en && (req.ready || req.drain);

endmodule

// File: rtl/i2c_fifo_notify.sv
module i2c_fifo_notify
    import fifonote_pkg::*;
#(
    parameter int  SIZE_CODE = 1,
    parameter int  CNT_W     = 16,
    localparam int DEPTH     = depth_of(SIZE_CODE),
    localparam int LW        = $clog2(DEPTH) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_wr,
    input  logic [15:0]      cfg_wdata,
    output logic [15:0]      cfg_rdata,
    output logic [15:0]      buf_status,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt_rdata,
    input  logic             host_tx_push,
    input  logic [7:0]       host_tx_data,
    input  logic             host_rx_pop,
    output logic [7:0]       host_rx_data,
    input  logic             sh_tx_req,
    output logic [7:0]       sh_tx_data,
    input  logic             sh_rx_valid,
    input  logic [7:0]       sh_rx_data,
    output logic             tx_ready,
    output logic             tx_drain,
    output logic             rx_ready,
    output logic             rx_drain,
    output logic             tx_dma_req,
    output logic             rx_dma_req,
    output logic             tx_udf,
    output logic             rx_ovr
);

    dir_cfg_t         tx_cfg;
    dir_cfg_t         rx_cfg;
    logic             tx_flush;
    logic             rx_flush;
    logic [CNT_W-1:0] cnt_q;
    logic [LW-1:0]    tx_lvl;
    logic [LW-1:0]    rx_lvl;
    logic             tx_moved;
    logic             rx_moved;
    logic [1:0]       dec_amt;
    logic             tx_udf_q;
    logic             rx_ovr_q;

    dir_cfg_t         dcfg [2];
    logic [LW-1:0]    dlvl [2];
    dir_req_t         dreq [2];

    assign dec_amt = {1'b0, tx_moved} + {1'b0, rx_moved};

    fifonote_regs #(.CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_wr    (cfg_wr),
        .cfg_wdata (cfg_wdata),
        .cnt_wr    (cnt_wr),
        .cnt_wdata (cnt_wdata),
        .dec_amt   (dec_amt),
        .tx_cfg    (tx_cfg),
        .rx_cfg    (rx_cfg),
        .tx_flush  (tx_flush),
        .rx_flush  (rx_flush),
        .cnt       (cnt_q)
    );

    fifonote_fifo #(.DEPTH(DEPTH), .SIDE(DIR_TX)) u_txq (
        .clk       (clk),
        .rst       (rst),
        .flush     (tx_flush),
        .push      (host_tx_push),
        .push_data (host_tx_data),
        .pop       (sh_tx_req),
        .head      (sh_tx_data),
        .level     (tx_lvl),
        .sh_moved  (tx_moved)
    );

    fifonote_fifo #(.DEPTH(DEPTH), .SIDE(DIR_RX)) u_rxq (
        .clk       (clk),
        .rst       (rst),
        .flush     (rx_flush),
        .push      (sh_rx_valid),
        .push_data (sh_rx_data),
        .pop       (host_rx_pop),
        .head      (host_rx_data),
        .level     (rx_lvl),
        .sh_moved  (rx_moved)
    );

    assign dcfg[0] = tx_cfg;
    assign dcfg[1] = rx_cfg;
    assign dlvl[0] = tx_lvl;
    assign dlvl[1] = rx_lvl;

    generate
        for (genvar d = 0; d < 2; d++) begin : g_dir
            fifonote_notify #(
                .DIR   ((d == 0) ? DIR_TX : DIR_RX),
                .DEPTH (DEPTH),
                .CNT_W (CNT_W)
            ) u_note (
                .cfg   (dcfg[d]),
                .level (dlvl[d]),
                .cnt   (cnt_q),
                .req   (dreq[d])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_udf_q <= 1'b0;
            rx_ovr_q <= 1'b0;
        end else begin
            tx_udf_q <= sh_tx_req && (tx_lvl == '0);
            rx_ovr_q <= sh_rx_valid && (rx_lvl == LW'(DEPTH));
        end
    end

    assign cfg_rdata  = cfg_pack(tx_cfg, rx_cfg);
    assign buf_status = {2'(SIZE_CODE), {SIZE_LSB{1'b0}}};
    assign cnt_rdata  = cnt_q;
    assign tx_ready   = dreq[0].ready;
    assign tx_drain   = dreq[0].drain;
    assign tx_dma_req = dreq[0].dma;
    assign rx_ready   = dreq[1].ready;
    assign rx_drain   = dreq[1].drain;
    assign rx_dma_req = dreq[1].dma;
    assign tx_udf     = tx_udf_q;
    assign rx_ovr     = rx_ovr_q;

endmodule

// File: rtl/fifonote_chk.sv
module fifonote_chk
    import fifonote_pkg::*;
#(
    parameter int  SIZE_CODE = 1,
    parameter int  CNT_W     = 16,
    localparam int DEPTH     = depth_of(SIZE_CODE),
    localparam int LW        = $clog2(DEPTH) + 1
) (
    input logic             clk,
    input logic             rst,
    input logic             tx_flush,
    input logic             rx_flush,
    input logic             cnt_wr,
    input logic [CNT_W-1:0] cnt_rdata,
    input logic             sh_tx_req,
    input logic             sh_rx_valid,
    input logic [LW-1:0]    tx_lvl,
    input logic [LW-1:0]    rx_lvl,
    input logic             tx_dma_en,
    input logic             rx_dma_en,
    input logic             tx_ready,
    input logic             tx_drain,
    input logic             rx_ready,
    input logic             rx_drain,
    input logic             tx_dma_req,
    input logic             rx_dma_req,
    input logic             tx_udf,
    input logic             rx_ovr
);

    assert_tx_flush_R2: assert property (@(posedge clk) disable iff (rst)
        tx_flush |=> (tx_lvl == '0));

    assert_rx_flush_R2: assert property (@(posedge clk) disable iff (rst)
        rx_flush |=> (rx_lvl == '0));

    assert_ready_drain_excl_R6: assert property (@(posedge clk) disable iff (rst)
        !(tx_ready && tx_drain) && !(rx_ready && rx_drain));

    assert_zero_count_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        (cnt_rdata == '0) |-> !(tx_ready || tx_drain || rx_ready || rx_drain));

    assert_count_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!cnt_wr && !sh_tx_req && !sh_rx_valid) |=> $stable(cnt_rdata));

    assert_overrun_R9: assert property (@(posedge clk) disable iff (rst)
        (sh_rx_valid && (rx_lvl == LW'(DEPTH))) |=> rx_ovr);

    assert_underflow_R10: assert property (@(posedge clk) disable iff (rst)
        (sh_tx_req && (tx_lvl == '0)) |=> (tx_udf && $stable(cnt_rdata)));

    assert_level_bound_R11: assert property (@(posedge clk) disable iff (rst)
        (tx_lvl <= LW'(DEPTH)) && (rx_lvl <= LW'(DEPTH)));

    assert_dma_gate_R12: assert property (@(posedge clk) disable iff (rst)
        (!tx_dma_en |-> !tx_dma_req) and (!rx_dma_en |-> !rx_dma_req));

endmodule

bind i2c_fifo_notify fifonote_chk #(.SIZE_CODE(SIZE_CODE), .CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .tx_flush    (tx_flush),
    .rx_flush    (rx_flush),
    .cnt_wr      (cnt_wr),
    .cnt_rdata   (cnt_rdata),
    .sh_tx_req   (sh_tx_req),
    .sh_rx_valid (sh_rx_valid),
    .tx_lvl      (tx_lvl),
    .rx_lvl      (rx_lvl),
    .tx_dma_en   (tx_cfg.dma_en),
    .rx_dma_en   (rx_cfg.dma_en),
    .tx_ready    (tx_ready),
    .tx_drain    (tx_drain),
    .rx_ready    (rx_ready),
    .rx_drain    (rx_drain),
    .tx_dma_req  (tx_dma_req),
    .rx_dma_req  (rx_dma_req),
    .tx_udf      (tx_udf),
    .rx_ovr      (rx_ovr)
);

// File: tb/sim_i2c_fifo_notify.sv
module sim_i2c_fifo_notify;

    localparam int CNT_W = 16;

    logic             clk;
    logic             rst;
    logic             cfg_wr;
    logic [15:0]      cfg_wdata;
    logic [15:0]      cfg_rdata;
    logic [15:0]      buf_status;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wdata;
    logic [CNT_W-1:0] cnt_rdata;
    logic             host_tx_push;
    logic [7:0]       host_tx_data;
    logic             host_rx_pop;
    logic [7:0]       host_rx_data;
    logic             sh_tx_req;
    logic [7:0]       sh_tx_data;
    logic             sh_rx_valid;
    logic [7:0]       sh_rx_data;
    logic             tx_ready;
    logic             tx_drain;
    logic             rx_ready;
    logic             rx_drain;
    logic             tx_dma_req;
    logic             rx_dma_req;
    logic             tx_udf;
    logic             rx_ovr;

    int total = 0;
    int bad   = 0;

    i2c_fifo_notify #(.SIZE_CODE(1), .CNT_W(CNT_W)) u0 (
        .clk(clk), .rst(rst),
        .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .buf_status(buf_status),
        .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt_rdata(cnt_rdata),
        .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
        .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
        .sh_tx_req(sh_tx_req), .sh_tx_data(sh_tx_data),
        .sh_rx_valid(sh_rx_valid), .sh_rx_data(sh_rx_data),
        .tx_ready(tx_ready), .tx_drain(tx_drain),
        .rx_ready(rx_ready), .rx_drain(rx_drain),
        .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
        .tx_udf(tx_udf), .rx_ovr(rx_ovr)
    );

    initial clk = 1'b0;
    always #5 clk = ~clk;

    // Vector: config word (flush bits set), host tx pushes, shifter rx bytes,
    // count, expected {tx_ready, tx_drain, rx_ready, rx_drain}. Depth is 16.
    typedef struct packed {
        logic [15:0] cfg;
        logic [7:0]  txn;
        logic [7:0]  rxn;
        logic [15:0] cnt;
        logic [3:0]  exp;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{16'h4343, 8'd0,  8'd4,  16'd10,  4'b1010},
        '{16'h4343, 8'd13, 8'd3,  16'd10,  4'b0000},
        '{16'h4747, 8'd0,  8'd0,  16'd5,   4'b0101},
        '{16'h4040, 8'd16, 8'd1,  16'd1,   4'b0010},
        '{16'h4F4F, 8'd0,  8'd16, 16'd16,  4'b1010},
        '{16'h4F4F, 8'd0,  8'd16, 16'd0,   4'b0000},
        '{16'h417F, 8'd0,  8'd2,  16'd100, 4'b0010},
        '{16'h4442, 8'd0,  8'd0,  16'd4,   4'b1001}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [15:0] v);
        cfg_wr = 1'b1; cfg_wdata = v;
        tick();
        cfg_wr = 1'b0;
    endtask

    task automatic load_cnt(input int v);
        cnt_wr = 1'b1; cnt_wdata = CNT_W'(v);
        tick();
        cnt_wr = 1'b0;
    endtask

    task automatic host_push(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            host_tx_push = 1'b1; host_tx_data = base + 8'(i);
            tick();
        end
        host_tx_push = 1'b0;
    endtask

    task automatic sh_put(input int n, input logic [7:0] base);
        for (int i = 0; i < n; i++) begin
            sh_rx_valid = 1'b1; sh_rx_data = base + 8'(i);
            tick();
        end
        sh_rx_valid = 1'b0;
    endtask

    task automatic sh_take();
        sh_tx_req = 1'b1;
        tick();
        sh_tx_req = 1'b0;
    endtask

    task automatic host_pop();
        host_rx_pop = 1'b1;
        tick();
        host_rx_pop = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; cfg_wr = 1'b0; cfg_wdata = '0; cnt_wr = 1'b0; cnt_wdata = '0;
        host_tx_push = 1'b0; host_tx_data = '0; host_rx_pop = 1'b0;
        sh_tx_req = 1'b0; sh_rx_valid = 1'b0; sh_rx_data = '0;
        repeat (3) tick();
        rst = 1'b0;

        // Reset state
        chk("R1 reset cfg", int'(cfg_rdata), 0);
        chk("R3 size code", int'(buf_status), 16'h4000);
        chk("R7 reset requests", int'({tx_ready, tx_drain, rx_ready, rx_drain}), 0);
        chk("R8 reset count", int'(cnt_rdata), 0);
        chk("R10 reset udf", int'(tx_udf), 0);
        chk("R9 reset ovr", int'(rx_ovr), 0);

        // Table of threshold patterns (R4 R5 R6 R7, R1 readback)
        foreach (VECS[k]) begin
            write_cfg(VECS[k].cfg);
            host_push(int'(VECS[k].txn), 8'h10);
            sh_put(int'(VECS[k].rxn), 8'h20);
            load_cnt(int'(VECS[k].cnt));
            chk($sformatf("R1 vec%0d readback", k), int'(cfg_rdata),
                int'(VECS[k].cfg & 16'hBFBF));
            chk($sformatf("R4 vec%0d tx_ready", k), int'(tx_ready), int'(VECS[k].exp[3]));
            chk($sformatf("R6 vec%0d tx_drain", k), int'(tx_drain), int'(VECS[k].exp[2]));
            chk($sformatf("R5 vec%0d rx_ready", k), int'(rx_ready), int'(VECS[k].exp[1]));
            chk($sformatf("R6 vec%0d rx_drain", k), int'(rx_drain), int'(VECS[k].exp[0]));
        end

        // R11 transmit order, R8 countdown, R10 underflow
        write_cfg(16'h4040);
        host_push(3, 8'hA1);
        load_cnt(10);
        for (int i = 0; i < 3; i++) begin
            chk("R11 tx order", int'(sh_tx_data), int'(8'hA1 + 8'(i)));
            sh_take();
        end
        chk("R8 count after tx", int'(cnt_rdata), 7);
        sh_take();
        chk("R10 underflow pulse", int'(tx_udf), 1);
        chk("R10 count unchanged", int'(cnt_rdata), 7);
        tick();
        chk("R10 pulse one cycle", int'(tx_udf), 0);

        // R11 receive order, R8 countdown
        sh_put(2, 8'hB1);
        chk("R8 count after rx", int'(cnt_rdata), 5);
        chk("R11 rx order first", int'(host_rx_data), 8'hB1);
        host_pop();
        chk("R11 rx order second", int'(host_rx_data), 8'hB2);
        host_pop();

        // R9 overrun, R8 saturation, R13 empty pop
        sh_put(16, 8'hC0);
        chk("R8 count stops at zero", int'(cnt_rdata), 0);
        chk("R9 no ovr at exact fill", int'(rx_ovr), 0);
        sh_put(1, 8'hEE);
        chk("R9 overrun pulse", int'(rx_ovr), 1);
        tick();
        chk("R9 pulse one cycle", int'(rx_ovr), 0);
        for (int i = 0; i < 15; i++) host_pop();
        chk("R9 overrun byte discarded", int'(host_rx_data), 8'hCF);
        host_pop();
        host_pop();
        sh_put(1, 8'h77);
        chk("R13 pop on empty ignored", int'(host_rx_data), 8'h77);

        // R13 push into full transmit queue
        write_cfg(16'h4040);
        host_push(16, 8'hD0);
        host_push(1, 8'h99);
        load_cnt(20);
        for (int i = 0; i < 15; i++) sh_take();
        chk("R13 last kept byte", int'(sh_tx_data), 8'hDF);
        sh_take();
        sh_take();
        chk("R13 extra push dropped", int'(tx_udf), 1);
        chk("R8 count after 16 taken", int'(cnt_rdata), 4);

        // R12 DMA gating
        write_cfg(16'hC3C3);
        load_cnt(10);
        chk("R12 tx dma on ready", int'(tx_dma_req), 1);
        chk("R12 rx dma idle", int'(rx_dma_req), 0);
        load_cnt(2);
        chk("R12 dma on drain", int'({tx_dma_req, rx_dma_req}), 3);
        write_cfg(16'h4343);
        chk("R12 dma disabled", int'({tx_dma_req, rx_dma_req}), 0);
        chk("R6 drain still set", int'(tx_drain), 1);

        // R2 flush per direction
        write_cfg(16'h4F4F);
        host_push(16, 8'h00);
        load_cnt(20);
        chk("R2 tx full not ready", int'(tx_ready), 0);
        write_cfg(16'h0F4F);
        chk("R2 tx flush frees queue", int'(tx_ready), 1);
        chk("R1 flush bit reads 0", int'(cfg_rdata), 16'h0F0F);
        write_cfg(16'h4343);
        sh_put(4, 8'h30);
        load_cnt(10);
        chk("R5 rx ready at threshold", int'(rx_ready), 1);
        write_cfg(16'h4303);
        chk("R2 rx flush empties", int'(rx_ready), 0);
        chk("R2 tx untouched", int'(tx_ready), 1);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule